// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single pulse-width request into two gate enables for the high-side and low-side switches of a synchronous buck stage. It never uses a fixed dead time. Each handoff between the switches waits for sensed evidence that the switch being released is actually off. The low side is applied once a digitized comparator reports that the switch node has dropped. The high side is applied once the low-side gate voltage is reported low.

When the inductor current is negative, the switch node may never fall. A dwell timer therefore covers that case: it applies the low side after a fixed number of cycles, so the current can recirculate. Each high-side pulse is also cut at a share of the nominal switching period, which bounds the duty cycle. A global kill input clears both gates in the same cycle and parks the sequencer in an idle state.

The pins are plain control signals sampled on the clock. No data stream passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `gate_handoff_seq`

## Requirements
- R1: `hs_en` and `ls_en` are never high in the same cycle.
- R2: After the high side is released, `ls_en` rises in the cycle after the first rising clock edge at which `phase_low` is sampled high.
- R3: After the low side is released, `hs_en` rises in the cycle after the first rising clock edge at which `lsg_low` is sampled high. There is no timeout on this path.
- R4: If `phase_low` stays low, `ls_en` rises exactly `WD_CYC` cycles (default 16) after `hs_en` fell.
- R5: A high-side pulse lasts at most `PERIOD_CYC*MAX_DUTY_PCT/100` cycles (default 16). After such a cut, `hs_en` stays low until `pwm_req` has been seen low and then high again.
- R6: While `kill` is high, both enables are low in that same cycle. On the next edge the sequencer goes idle.
- R7: A handoff that has begun runs to completion whatever `pwm_req` does meanwhile. The pending gate is still applied when its feedback arrives, even if the request has already changed back.
- R8: While `rst_n` is low, both enables are low.
- R9: From idle, a high `pwm_req` starts a high-side handoff that waits on `lsg_low`. A low `pwm_req` starts a low-side handoff that waits on `phase_low` or on the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | Requested switch: 1 = high side, 0 = low side |
| phase_low | input | 1 | Switch node sensed below its low threshold |
| lsg_low | input | 1 | Low-side gate voltage sensed as fallen |
| kill | input | 1 | Force both gates off and return to idle |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
Every gate change is registered once, so a feedback bit sampled at a rising edge shows on the enable one cycle later. The kill input reaches both enables combinationally, within the same cycle.

The bench drives all inputs on falling edges and reads the outputs on the next falling edge. Gap lengths and pulse widths are then counted in whole cycles: a switch-node delay of d cycles must give a gap of min(d+1, WD_CYC), a gate delay of d cycles must give d+1, and a held request of L cycles must give a pulse of min(L, cap). The bench sweeps d and L across the whole range either side of each limit.

// File: rtl/gate_handoff_pkg.sv
package gate_handoff_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_LG = 3'd1,
    ST_HS      = 3'd2,
    ST_WAIT_PH = 3'd3,
    ST_LS      = 3'd4
  } seq_state_t;
endpackage

// File: rtl/gate_dwell_timer.sv
module gate_dwell_timer #(
  parameter int CNT_W = 6,
  parameter int LIM_A = 16,
  parameter int LIM_B = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic hit_a,
  output logic hit_b
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TGT_A   = CNT_W'(LIM_A - 1);
  localparam logic [CNT_W-1:0] TGT_B   = CNT_W'(LIM_B - 1);

  logic [CNT_W-1:0] cnt_q;

  // Cycles spent in the current state; saturates rather than wrapping.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_a = (cnt_q == TGT_A);
  assign hit_b = (cnt_q == TGT_B);
endmodule

// File: rtl/gate_handoff_fsm.sv
module gate_handoff_fsm
  import gate_handoff_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_req,
  input  logic       phase_low,
  input  logic       lsg_low,
  input  logic       kill,
  input  logic       wd_hit,
  input  logic       on_hit,
  output seq_state_t state,
  output logic       restart
);
  seq_state_t state_q, state_d;
  logic       capped_q, capped_d;

  always_comb begin
    state_d  = state_q;
    capped_d = capped_q & pwm_req;
    if (kill) begin
      state_d  = ST_IDLE;
      capped_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:    state_d = pwm_req ? ST_WAIT_LG : ST_WAIT_PH;
        ST_WAIT_LG: if (lsg_low) state_d = ST_HS;
        ST_HS: begin
          if (!pwm_req) begin
            state_d = ST_WAIT_PH;
          end else if (on_hit) begin
            state_d  = ST_WAIT_PH;
            capped_d = 1'b1;
          end
        end
        ST_WAIT_PH: if (phase_low || wd_hit) state_d = ST_LS;
        ST_LS:      if (pwm_req && !capped_q) state_d = ST_WAIT_LG;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      capped_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      capped_q <= capped_d;
    end
  end

  assign state   = state_q;
  assign restart = (state_d != state_q);
endmodule

// File: rtl/gate_handoff_seq.sv
module gate_handoff_seq
  import gate_handoff_pkg::*;
#(
  parameter int PERIOD_CYC   = 20,
  parameter int MAX_DUTY_PCT = 80,
  parameter int WD_CYC       = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_req,
  input  logic phase_low,
  input  logic lsg_low,
  input  logic kill,
  output logic hs_en,
  output logic ls_en
);
  localparam int MAX_ON  = (PERIOD_CYC * MAX_DUTY_PCT) / 100;
  localparam int LONGEST = (MAX_ON > WD_CYC) ? MAX_ON : WD_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1) + 1;

  seq_state_t state;
  logic       restart, wd_hit, on_hit;

  gate_dwell_timer #(
    .CNT_W(CNT_W),
    .LIM_A(WD_CYC),
    .LIM_B(MAX_ON)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .hit_a  (wd_hit),
    .hit_b  (on_hit)
  );

  gate_handoff_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_req  (pwm_req),
    .phase_low(phase_low),
    .lsg_low  (lsg_low),
    .kill     (kill),
    .wd_hit   (wd_hit),
    .on_hit   (on_hit),
    .state    (state),
    .restart  (restart)
  );

  // Kill gates both enables without waiting for a clock edge.
  assign hs_en = (state == ST_HS) && !kill;
  assign ls_en = (state == ST_LS) && !kill;
endmodule

// File: rtl/gate_handoff_seq_chk.sv
module gate_handoff_seq_chk #(
  parameter int MAX_ON = 16,
  parameter int WD_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic kill,
  input logic lsg_low,
  input logic hs_en,
  input logic ls_en
);
  logic [15:0] on_run, gap_run;
  logic        armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_run  <= '0;
      gap_run <= '0;
      armed   <= 1'b0;
    end else begin
      on_run <= hs_en ? ((on_run == 16'hFFFF) ? on_run : on_run + 1'b1) : '0;
      if (kill || ls_en) armed <= 1'b0;
      else if (hs_en)    armed <= 1'b1;
      if (armed && !hs_en && !ls_en && !kill)
        gap_run <= (gap_run == 16'hFFFF) ? gap_run : gap_run + 1'b1;
      else
        gap_run <= '0;
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  p_ls_after_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> $past(!hs_en));

  p_hs_after_lsg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(lsg_low));

  p_wd_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gap_run <= 16'(WD_CYC));

  p_on_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    on_run <= 16'(MAX_ON));

  p_kill_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!hs_en && !ls_en));
endmodule

bind gate_handoff_seq gate_handoff_seq_chk #(
  .MAX_ON(MAX_ON),
  .WD_CYC(WD_CYC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .kill   (kill),
  .lsg_low(lsg_low),
  .hs_en  (hs_en),
  .ls_en  (ls_en)
);

// File: tb/gate_handoff_seq_tb.sv
module gate_handoff_seq_tb;
  localparam int PERIOD_CYC = 20;
  localparam int DUTY       = 80;
  localparam int WD         = 16;
  localparam int CAP        = (PERIOD_CYC * DUTY) / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_req = 1'b0, phase_low = 1'b0, lsg_low = 1'b0, kill = 1'b0;
  logic hs_en, ls_en;
  int   n_tests = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  gate_handoff_seq #(.PERIOD_CYC(PERIOD_CYC), .MAX_DUTY_PCT(DUTY), .WD_CYC(WD)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .phase_low(phase_low),
    .lsg_low(lsg_low), .kill(kill), .hs_en(hs_en), .ls_en(ls_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go_ls;
    @(negedge clk); kill = 1'b1; pwm_req = 1'b0; phase_low = 1'b1; lsg_low = 1'b0;
    @(negedge clk); kill = 1'b0;
    repeat (3) @(negedge clk);
    chk(ls_en && !hs_en, "R9 idle to low side", ls_en, 1);
  endtask

  task automatic go_hs;
    go_ls();
    lsg_low = 1'b1; pwm_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(hs_en && !ls_en, "R3 reach high side", hs_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!hs_en && !ls_en, "R8 reset", {hs_en, ls_en}, 0);
    rst_n = 1'b1;

    // R2/R4: switch-node delay sweep, gap = min(d+1, WD)
    for (int d = 0; d <= WD + 3; d++) begin
      int gap;
      bit olap;
      go_hs();
      pwm_req = 1'b0; phase_low = 1'b0;
      gap = 0; olap = 0;
      for (int k = 1; k < 60; k++) begin
        @(negedge clk);
        if (ls_en) break;
        if (hs_en) olap = 1;
        gap++;
        if (k - 1 == d) phase_low = 1'b1;
      end
      chk(gap == ((d + 1 < WD) ? d + 1 : WD), (d + 1 < WD) ? "R2 phase gap" : "R4 watchdog gap",
          gap, (d + 1 < WD) ? d + 1 : WD);
      chk(!olap, "R1 no high side in gap", olap, 0);
    end

    // R3: gate-feedback delay sweep, gap = d+1 with no timeout
    for (int d = 0; d <= WD + 6; d++) begin
      int gap;
      go_ls();
      pwm_req = 1'b1; lsg_low = 1'b0;
      gap = 0;
      for (int k = 1; k < 60; k++) begin
        @(negedge clk);
        if (hs_en) break;
        gap++;
        if (k - 1 == d) lsg_low = 1'b1;
      end
      chk(gap == d + 1, "R3 gate gap", gap, d + 1);
    end

    // R5: held request sweep, width = min(L, CAP)
    for (int len = 1; len <= CAP + 4; len++) begin
      int w;
      bit relit;
      go_hs();
      w = 1;
      if (w == len) pwm_req = 1'b0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (!hs_en) break;
        w++;
        if (w == len) pwm_req = 1'b0;
      end
      chk(w == ((len < CAP) ? len : CAP), "R5 pulse width", w, (len < CAP) ? len : CAP);
      if (pwm_req) begin
        relit = 0;
        repeat (6) begin @(negedge clk); if (hs_en) relit = 1; end
        chk(!relit && ls_en, "R5 locked after cap", relit, 0);
        pwm_req = 1'b0; @(negedge clk);
        pwm_req = 1'b1; repeat (2) @(negedge clk);
        chk(hs_en, "R5 rearm after low", hs_en, 1);
        pwm_req = 1'b0;
      end
    end

    // R6: kill cuts high side in the same cycle, stays off, then idle
    go_hs();
    pwm_req = 1'b0; phase_low = 1'b1; kill = 1'b1;
    #1 chk(!hs_en && !ls_en, "R6 kill immediate", hs_en, 0);
    repeat (3) begin @(negedge clk); chk(!hs_en && !ls_en, "R6 kill hold", {hs_en, ls_en}, 0); end
    kill = 1'b0;
    @(negedge clk); chk(!ls_en, "R6 idle then wait", ls_en, 0);
    @(negedge clk); chk(ls_en, "R9 low-side path after idle", ls_en, 1);

    // R6: kill cuts low side too
    kill = 1'b1;
    #1 chk(!ls_en, "R6 kill low side", ls_en, 1'b0);
    @(negedge clk); kill = 1'b0;

    // R7: request returns high while waiting on switch node
    go_hs();
    pwm_req = 1'b0; phase_low = 1'b0;
    @(negedge clk); pwm_req = 1'b1;
    @(negedge clk); chk(!ls_en && !hs_en, "R7 still waiting", ls_en, 0);
    phase_low = 1'b1;
    @(negedge clk); chk(ls_en, "R7 low side completes", ls_en, 1);
    @(negedge clk); chk(!ls_en, "R7 then hands back", ls_en, 0);

    // R7: request drops while waiting on low-side gate
    go_ls();
    pwm_req = 1'b1; lsg_low = 1'b0;
    @(negedge clk); pwm_req = 1'b0;
    @(negedge clk); chk(!hs_en, "R7 gate pending", hs_en, 0);
    lsg_low = 1'b1;
    @(negedge clk); chk(hs_en, "R7 high side completes", hs_en, 1);
    @(negedge clk); chk(!hs_en, "R7 high side released", hs_en, 0);

    // R9: idle with request held high waits on lsg_low
    @(negedge clk); kill = 1'b1; pwm_req = 1'b1; lsg_low = 1'b0;
    @(negedge clk); kill = 1'b0;
    repeat (4) @(negedge clk);
    chk(!hs_en && !ls_en, "R9 idle high path waits", {hs_en, ls_en}, 0);
    lsg_low = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(hs_en, "R9 idle high path", hs_en, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule